// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block receives asynchronous serial frames on a single line whose resting level is 1. A separate quantum-rate enable divides time into quanta, and a bit time lasts a programmable number of quanta. The receiver waits for a falling edge and checks the start bit at a programmable sample point. It then collects a programmable number of data bits, least significant bit first, followed by an optional even-parity bit and one or two stop bits. Each bit is decided either from one sample or from a majority vote over three consecutive quanta.

An idle tracker counts consecutive passive bit times on the line. A new frame is accepted only once the line has been seen idle, unless idle checking is switched off. A format error drops the idle state, so the receiver cannot lock onto the middle of a stream. Single-cycle pulses report a received word, stop-bit errors, parity errors and noisy samples. An optional busy level covers each frame. Baud-rate generation and software access sit outside the block.

Top module: `osr_serial_rx`

## Requirements
- R1: After synchronous reset, rx_valid, frame_err, par_err, noise_pulse and rx_busy are 0 and rx_data is all zeros. With cfg_idle_chk=1, rx_idle is 0.
- R2: A frame is a 0 start bit, then cfg_len+1 data bits sent least significant bit first, then optional parity, then stop bits. After the frame, rx_data holds the data right-aligned with the upper bits zero, and rx_valid pulses high for exactly one clock.
- R3: With cfg_vote=0, each bit is taken from the single quantum whose index within the bit equals cfg_sp, counted from 0. The value on any other quantum has no effect on the word, and noise_pulse stays 0.
- R4: With cfg_vote=1, each bit is the majority of quanta cfg_sp-2, cfg_sp-1 and cfg_sp. When those three disagree, noise_pulse pulses once for that bit.
- R5: If the start bit reads 1 at its sample point, the receiver returns to waiting for an edge. No word is delivered and rx_busy returns to 0.
- R6: cfg_two_stop selects one (0) or two (1) stop bits. A frame completes at the sample point of its last stop bit, so a new start bit may follow directly. Any stop bit read as 0 raises frame_err in the same cycle as rx_valid, and the word is still delivered.
- R7: With cfg_par_en=1, one parity bit follows the data. The data bits and the parity bit together must hold an even number of ones. Otherwise par_err pulses in the same cycle as rx_valid.
- R8: With cfg_idle_chk=1, rx_idle rises once the line has been 1 for (cfg_len+1)+2 bit times in a row, or (cfg_len+1)+3 with parity. Any 0 quantum restarts this count. A falling edge seen while rx_idle is 0 does not start a frame.
- R9: With cfg_idle_chk=0, rx_idle is 1 from reset onwards, and frames are accepted without any idle wait.
- R10: A frame that ends with a format error clears the idle state. With cfg_idle_chk=1, rx_idle is then 0 until a fresh run of passive bit times has been counted.
- R11: With cfg_busy_en=1, rx_busy is high from start-bit detection until the frame completes. With cfg_busy_en=0, rx_busy stays 0.
- R12: The receiver advances only on clocks where qen_i is 1. The decoded result does not depend on how many idle clocks separate two quanta.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, resting level 1 |
| qen_i | input | 1 | One-clock enable per time quantum |
| cfg_qpb | input | QW | Quanta per bit minus one (at least 2) |
| cfg_sp | input | QW | Sample-point quantum index (2..cfg_qpb) |
| cfg_len | input | LW | Data bits per frame minus one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_vote | input | 1 | 0 single sample, 1 three-sample majority |
| cfg_two_stop | input | 1 | 0 one stop bit, 1 two stop bits |
| cfg_idle_chk | input | 1 | Require idle line before accepting frames |
| cfg_busy_en | input | 1 | Enable the rx_busy level |
| rx_data | output | 2**LW | Received word, right-aligned |
| rx_valid | output | 1 | One-clock pulse per completed frame |
| frame_err | output | 1 | Stop-bit error, alongside rx_valid |
| par_err | output | 1 | Parity mismatch, alongside rx_valid |
| noise_pulse | output | 1 | Majority samples of a bit disagreed |
| rx_busy | output | 1 | Frame in progress |
| rx_idle | output | 1 | Line considered idle |

## Verification
The bench builds the block with its defaults: 5-bit quantum fields, 4-bit length, giving 16-bit words, and a two-stage input synchronizer. This makes every data length from 1 to 16 bits reachable. The bench exercises up to 16 quanta per bit, with sample points spread from the third quantum to the last. Quantum enables arrive either every clock or with idle gaps. Directed cases pin the exact idle threshold with and without parity, and glitches are placed on chosen quanta around the sample point.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    // Two-of-three vote
    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Passive bit times needed before the line counts as idle.
    // len_m1 is data bits minus one.
    function automatic int idle_threshold(input int len_m1, input logic par_en);
        return len_m1 + 1 + 2 + (par_en ? 1 : 0);
    endfunction

endpackage

// File: rtl/osr_sync.sv
module osr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    for (genvar i = 0; i < STAGES; i++) begin : g_st
        logic s;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) s <= 1'b1;
                else     s <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) s <= 1'b1;
                else     s <= g_st[i-1].s;
            end
        end
    end

    assign q_o = g_st[STAGES-1].s;
endmodule

// File: rtl/osr_bit_sampler.sv
module osr_bit_sampler
    import osr_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic qen_i,
    input  logic line_i,
    input  logic vote_i,
    output logic bit_o,
    output logic noisy_o
);
    // hist[0] holds the previous quantum, hist[1] the one before it
    logic [1:0] hist;

    always_ff @(posedge clk) begin
        if (rst)        hist <= 2'b11;
        else if (qen_i) hist <= {hist[0], line_i};
    end

    assign bit_o   = vote_i ? majority3(hist[1], hist[0], line_i) : line_i;
    assign noisy_o = vote_i && !((hist[1] == hist[0]) && (hist[0] == line_i));
endmodule

// File: rtl/osr_idle_tracker.sv
module osr_idle_tracker #(
    parameter int QW = 5,
    parameter int BW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          qen_i,
    input  logic          line_i,
    input  logic [QW-1:0] qpb_i,
    input  logic [BW-1:0] thr_i,
    input  logic          clear_i,
    output logic          idle_o
);
    logic [QW-1:0] qc;
    logic [BW-1:0] bc;
    logic          flag;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            qc   <= '0;
            bc   <= '0;
            flag <= 1'b0;
        end else if (qen_i && !flag) begin
            if (!line_i) begin
                qc <= '0;
                bc <= '0;
            end else if (qc == qpb_i) begin
                qc <= '0;
                bc <= bc + BW'(1);
                if ((bc + BW'(1)) >= thr_i) flag <= 1'b1;
            end else begin
                qc <= qc + QW'(1);
            end
        end
    end

    assign idle_o = flag;

    // R8
    idle_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(line_i) && $past(qen_i)));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !flag);
endmodule

// File: rtl/osr_serial_rx.sv
module osr_serial_rx
    import osr_rx_pkg::*;
#(
    parameter int QW          = 5,
    parameter int LW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rxd_i,
    input  logic                  qen_i,
    input  logic [QW-1:0]         cfg_qpb,
    input  logic [QW-1:0]         cfg_sp,
    input  logic [LW-1:0]         cfg_len,
    input  logic                  cfg_par_en,
    input  logic                  cfg_vote,
    input  logic                  cfg_two_stop,
    input  logic                  cfg_idle_chk,
    input  logic                  cfg_busy_en,
    output logic [(1<<LW)-1:0]    rx_data,
    output logic                  rx_valid,
    output logic                  frame_err,
    output logic                  par_err,
    output logic                  noise_pulse,
    output logic                  rx_busy,
    output logic                  rx_idle
);
    localparam int DMAX = 1 << LW;
    localparam int BW   = $clog2(DMAX + 4) + 1;

    typedef struct packed {
        rx_state_e       st;
        logic [QW-1:0]   qcnt;
        logic [LW-1:0]   bidx;
        logic            sidx;
        logic [DMAX-1:0] data;
        logic            ferr;
        logic            perr;
    } ctx_t;

    logic          line;
    logic          samp_bit;
    logic          samp_noisy;
    logic          idle_ok;
    logic          idle_clr;
    logic [BW-1:0] thr;

    osr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rxd_i),
        .q_o (line)
    );

    osr_bit_sampler u_samp (
        .clk     (clk),
        .rst     (rst),
        .qen_i   (qen_i),
        .line_i  (line),
        .vote_i  (cfg_vote),
        .bit_o   (samp_bit),
        .noisy_o (samp_noisy)
    );

    assign thr = BW'(idle_threshold(int'(cfg_len), cfg_par_en));

    osr_idle_tracker #(.QW(QW), .BW(BW)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .qen_i   (qen_i),
        .line_i  (line),
        .qpb_i   (cfg_qpb),
        .thr_i   (thr),
        .clear_i (idle_clr),
        .idle_o  (idle_ok)
    );

    assign rx_idle = !cfg_idle_chk || idle_ok;

    ctx_t cur, nxt;
    logic fin;
    logic noise_n;
    logic at_sp, at_end;

    assign at_sp  = (cur.qcnt == cfg_sp);
    assign at_end = (cur.qcnt == cfg_qpb);

    always_comb begin
        nxt     = cur;
        fin     = 1'b0;
        noise_n = 1'b0;
        if (qen_i) begin
            if (cur.st == ST_HUNT) begin
                if (rx_idle && !line) begin
                    nxt.st   = ST_START;
                    nxt.qcnt = QW'(1);
                    nxt.bidx = '0;
                    nxt.sidx = 1'b0;
                    nxt.data = '0;
                    nxt.ferr = 1'b0;
                    nxt.perr = 1'b0;
                end
            end else begin
                nxt.qcnt = at_end ? '0 : cur.qcnt + QW'(1);
                if (at_sp) noise_n = samp_noisy;
                case (cur.st)
                    ST_START: begin
                        if (at_sp && samp_bit) begin
                            nxt.st   = ST_HUNT;
                            nxt.qcnt = '0;
                        end else if (at_end) begin
                            nxt.st = ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (at_sp) nxt.data[cur.bidx] = samp_bit;
                        if (at_end) begin
                            if (cur.bidx == cfg_len) nxt.st = cfg_par_en ? ST_PAR : ST_STOP;
                            else                     nxt.bidx = cur.bidx + LW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (at_sp) nxt.perr = samp_bit ^ (^cur.data);
                        if (at_end) nxt.st = ST_STOP;
                    end
                    ST_STOP: begin
                        if (at_sp) begin
                            nxt.ferr = cur.ferr | !samp_bit;
                            if (cur.sidx == cfg_two_stop) begin
                                fin      = 1'b1;
                                nxt.st   = ST_HUNT;
                                nxt.qcnt = '0;
                            end
                        end
                        if (at_end && !fin) nxt.sidx = 1'b1;
                    end
                    default: nxt.st = ST_HUNT;
                endcase
            end
        end
    end

    assign idle_clr = fin && nxt.ferr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= '0;
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            frame_err   <= 1'b0;
            par_err     <= 1'b0;
            noise_pulse <= 1'b0;
        end else begin
            cur         <= nxt;
            rx_valid    <= fin;
            frame_err   <= fin && nxt.ferr;
            par_err     <= fin && cur.perr;
            noise_pulse <= noise_n;
            if (fin) rx_data <= nxt.data;
        end
    end

    assign rx_busy = cfg_busy_en && (cur.st != ST_HUNT);

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6
    ferr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> rx_valid);

    // R7
    perr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        par_err |-> (rx_valid && $past(cfg_par_en)));

    // R4
    noise_vote_chk: assert property (@(posedge clk) disable iff (rst)
        noise_pulse |-> $past(cfg_vote));

    // R11
    busy_before_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ($past(rx_busy) || !$past(cfg_busy_en)));

    // R8
    valid_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(rx_idle));
endmodule

// File: tb/osr_serial_rx_bench.sv
module osr_serial_rx_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        rxd;
    logic        qen;
    logic [4:0]  cfg_qpb;
    logic [4:0]  cfg_sp;
    logic [3:0]  cfg_len;
    logic        cfg_par_en;
    logic        cfg_vote;
    logic        cfg_two_stop;
    logic        cfg_idle_chk;
    logic        cfg_busy_en;
    logic [15:0] rx_data;
    logic        rx_valid, frame_err, par_err, noise_pulse, rx_busy, rx_idle;

    always #10 clk = ~clk;   // 50 MHz

    osr_serial_rx u_osr_serial_rx (
        .clk(clk), .rst(rst), .rxd_i(rxd), .qen_i(qen),
        .cfg_qpb(cfg_qpb), .cfg_sp(cfg_sp), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_vote(cfg_vote), .cfg_two_stop(cfg_two_stop),
        .cfg_idle_chk(cfg_idle_chk), .cfg_busy_en(cfg_busy_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .par_err(par_err), .noise_pulse(noise_pulse), .rx_busy(rx_busy), .rx_idle(rx_idle)
    );

    int n_chk = 0, n_fail = 0;
    int vcnt = 0, ncnt = 0, cyc = 0;
    int gap = 0;
    logic [15:0] g_data;
    logic g_ferr, g_perr, b_mid;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                vcnt++;
                g_data = rx_data;
                g_ferr = frame_err;
                g_perr = par_err;
            end
            if (noise_pulse) ncnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12: actual=%0d cycles expected<%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_q(input logic v);
        rxd = v;
        qen = 1'b1;
        @(negedge clk);
        qen = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drive_bit(input logic v, input int gq);
        for (int q = 0; q <= int'(cfg_qpb); q++) drive_q((q == gq) ? ~v : v);
    endtask

    task automatic idle_quanta(input int n);
        for (int i = 0; i < n; i++) drive_q(1'b1);
    endtask

    function automatic int thr_bits();
        return int'(cfg_len) + 3 + (cfg_par_en ? 1 : 0);
    endfunction

    // serr: -1 none, else index of stop bit driven 0; gbit: data bit with glitch at quantum gq
    task automatic send_frame(input logic [15:0] d, input bit pflip, input int serr,
                              input int gbit, input int gq, input int tail);
        int nb;
        logic p;
        nb = int'(cfg_len) + 1;
        p = pflip;
        for (int i = 0; i < nb; i++) p ^= d[i];
        drive_bit(1'b0, -1);
        for (int i = 0; i < nb; i++) begin
            if (i == nb / 2) b_mid = rx_busy;
            drive_bit(d[i], (i == gbit) ? gq : -1);
        end
        if (cfg_par_en) drive_bit(p, -1);
        drive_bit((serr == 0) ? 1'b0 : 1'b1, -1);
        if (cfg_two_stop) drive_bit((serr == 1) ? 1'b0 : 1'b1, -1);
        idle_quanta(tail);
    endtask

    task automatic expect_frame(input string tag, input int vc0, input int nc0,
                                input logic [15:0] ed, input bit ef, input bit ep, input int en);
        check({tag, " valid count"}, vcnt - vc0, 1);
        check({tag, " data"}, g_data, ed);
        check({tag, " frame_err"}, g_ferr, ef);
        check({tag, " par_err"}, g_perr, ep);
        check({tag, " noise count"}, ncnt - nc0, en);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        qen = 1'b0;
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] mask16(input int nb);
        return 16'(((32'h1 << nb) - 1));
    endfunction

    int vc0, nc0, tailq;

    initial begin
        void'($urandom(32'd4242));
        cfg_qpb = 5'd7; cfg_sp = 5'd4; cfg_len = 4'd7; cfg_par_en = 1'b0;
        cfg_vote = 1'b0; cfg_two_stop = 1'b0; cfg_idle_chk = 1'b1; cfg_busy_en = 1'b1;
        gap = 0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        check("R1 rx_valid", rx_valid, 0);
        check("R1 rx_busy", rx_busy, 0);
        check("R1 rx_data", rx_data, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 noise_pulse", noise_pulse, 0);
        check("R1 rx_idle", rx_idle, 0);

        // R8 exact idle threshold without parity: 10 bits x 8 quanta
        idle_quanta(79);
        check("R8 idle just before threshold", rx_idle, 0);
        idle_quanta(2);
        check("R8 idle after threshold", rx_idle, 1);

        // R2 basic frame, R11 busy level
        tailq = int'(cfg_qpb) + 4;
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h00A5, 0, -1, -1, -1, tailq);
        expect_frame("R2 basic", vc0, nc0, 16'h00A5, 0, 0, 0);
        check("R11 busy mid frame", b_mid, 1);
        check("R11 busy after frame", rx_busy, 0);

        // R8 threshold with parity: 11 bits x 8 quanta
        cfg_par_en = 1'b1;
        do_reset();
        idle_quanta(87);
        check("R8 parity idle before threshold", rx_idle, 0);
        idle_quanta(2);
        check("R8 parity idle after threshold", rx_idle, 1);

        // R7 good parity and bad parity
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0037, 0, -1, -1, -1, tailq);
        expect_frame("R7 good parity", vc0, nc0, 16'h0037, 0, 0, 0);
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0037, 1, -1, -1, -1, tailq);
        expect_frame("R7 bad parity", vc0, nc0, 16'h0037, 0, 1, 0);
        cfg_par_en = 1'b0;

        // R6 two stop bits, second one 0; R10 idle dropped; R8 next frame ignored
        cfg_two_stop = 1'b1;
        idle_quanta(8 * 12);
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h00C3, 0, 1, -1, -1, tailq);
        expect_frame("R6 second stop error", vc0, nc0, 16'h00C3, 1, 0, 0);
        check("R10 idle cleared after format error", rx_idle, 0);
        vc0 = vcnt;
        send_frame(16'h005A, 0, -1, -1, -1, tailq);
        check("R8 frame ignored while not idle", vcnt - vc0, 0);
        idle_quanta((thr_bits() + 1) * 8);
        check("R8 idle regained", rx_idle, 1);
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0081, 0, -1, -1, -1, tailq);
        expect_frame("R6 two stops clean", vc0, nc0, 16'h0081, 0, 0, 0);
        cfg_two_stop = 1'b0;

        // R6 one stop bit, stop error, and back-to-back frames
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h00F0, 0, 0, -1, -1, tailq);
        expect_frame("R6 single stop error", vc0, nc0, 16'h00F0, 1, 0, 0);
        idle_quanta((thr_bits() + 1) * 8);
        vc0 = vcnt;
        send_frame(16'h0011, 0, -1, -1, -1, 0);
        send_frame(16'h00EE, 0, -1, -1, -1, tailq);
        check("R6 back-to-back count", vcnt - vc0, 2);
        check("R6 back-to-back data", g_data, 16'h00EE);

        // R9 idle check off: idle at once, frame accepted right after reset
        cfg_idle_chk = 1'b0;
        do_reset();
        check("R9 idle immediately", rx_idle, 1);
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0066, 0, -1, -1, -1, tailq);
        expect_frame("R9 frame without wait", vc0, nc0, 16'h0066, 0, 0, 0);

        // R5 false start: 2 quanta of 0 only
        vc0 = vcnt;
        drive_q(1'b0); drive_q(1'b0);
        idle_quanta(20);
        check("R5 false start no word", vcnt - vc0, 0);
        check("R5 false start busy low", rx_busy, 0);

        // R3 single sample: glitch next to sample point ignored, glitch on it taken
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0055, 0, -1, 2, 3, tailq);
        expect_frame("R3 glitch off sample point", vc0, nc0, 16'h0055, 0, 0, 0);
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0055, 0, -1, 2, 4, tailq);
        expect_frame("R3 glitch on sample point", vc0, nc0, 16'h0051, 0, 0, 0);

        // R4 majority vote with noise report
        cfg_vote = 1'b1;
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0055, 0, -1, 2, 4, tailq);
        expect_frame("R4 vote glitch on sample point", vc0, nc0, 16'h0055, 0, 0, 1);
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0055, 0, -1, 5, 2, tailq);
        expect_frame("R4 vote glitch early quantum", vc0, nc0, 16'h0055, 0, 0, 1);
        cfg_vote = 1'b0;

        // R11 busy disabled
        cfg_busy_en = 1'b0;
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h0099, 0, -1, -1, -1, tailq);
        expect_frame("R11 busy disabled frame", vc0, nc0, 16'h0099, 0, 0, 0);
        check("R11 busy stays low", b_mid, 0);
        cfg_busy_en = 1'b1;

        // R12 gaps between quanta
        gap = 2;
        vc0 = vcnt; nc0 = ncnt;
        send_frame(16'h003C, 0, -1, -1, -1, tailq);
        expect_frame("R12 gapped quanta", vc0, nc0, 16'h003C, 0, 0, 0);

        // Random frames (R2 R3 R4 R6 R7 R12)
        for (int k = 0; k < 30; k++) begin
            logic [15:0] d, ed;
            int nb, serr, gbit, gq;
            bit pflip, flipped, ef, ep;
            cfg_qpb      = 5'(3 + $urandom % 13);
            cfg_sp       = 5'(2 + $urandom % (int'(cfg_qpb) - 1));
            cfg_len      = 4'($urandom % 16);
            cfg_par_en   = 1'($urandom % 2);
            cfg_vote     = 1'($urandom % 2);
            cfg_two_stop = 1'($urandom % 2);
            cfg_idle_chk = 1'($urandom % 2);
            cfg_busy_en  = 1'($urandom % 2);
            gap          = $urandom % 3;
            nb   = int'(cfg_len) + 1;
            d    = 16'($urandom) & mask16(nb);
            pflip = ($urandom % 5) == 0;
            serr = (($urandom % 6) == 0) ? int'($urandom % 2) : -1;
            gbit = (($urandom % 3) == 0) ? int'($urandom % nb) : -1;
            gq   = int'(cfg_sp) - int'($urandom % (cfg_vote ? 3 : 2));
            flipped = (gbit >= 0) && !cfg_vote && (gq == int'(cfg_sp));
            ed = flipped ? (d ^ (16'h1 << gbit)) : d;
            ef = (serr == 0) || (cfg_two_stop && serr == 1);
            ep = cfg_par_en && (pflip ^ flipped);
            idle_quanta((thr_bits() + 2) * (int'(cfg_qpb) + 1));
            vc0 = vcnt; nc0 = ncnt;
            send_frame(d, pflip, serr, gbit, gq, int'(cfg_qpb) + 4);
            expect_frame("R2 random frame", vc0, nc0, ed, ef, ep,
                         (cfg_vote && gbit >= 0) ? 1 : 0);
            check("R11 random busy", b_mid, cfg_busy_en);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule